// File: doc/BRIEF.md
# PHY Power-Up Calibration Sequencer

This block brings a storage-interface PHY out of reset with no software involvement. When reset is released it walks a fixed list of sixteen steps. Each step drives one or two accesses on a simple request/acknowledge register master, and the register port behind that master reaches the PHY's internal configuration space. Most steps read a register, OR a constant mask into the value and write the result back. Two steps write a fixed value with no prior read. Two checkpoint steps idle for a programmable number of cycles, then read the pad status register and require its calibration-done flag to be set.

The sequence stops on the first fault and holds a two-bit error code. One code means calibration did not finish. The other means an access was not acknowledged in time. If every step completes, the sequencer raises a sticky done flag. After done or error it issues no further requests. The checkpoint wait is given in clock cycles, so a silicon build can use a window of about 10 ms while a test build uses a few cycles.

Top module: `phy_cal_seq`

## Requirements
- R1: While rst_ni is low, req_o, done_o and err_o are all 0, and err_code_o is 0.
- R2: The accesses appear in this order. A write of 0x00 to 0x24. Then RMW 0x01 with mask 0x40 and RMW 0x02 with mask 0x02. Then checkpoint A. Then RMW 0x01 with mask 0x02. Then checkpoint B. Then RMW with the masks 0x06/0x03, 0x08/0x02, 0x20/0x01, 0x07/0xFF, 0x09/0xFF, 0x21/0xFF, 0x22/0x01, 0x23/0x01 and 0x0F/0x07. Last, a write of 0x04 to 0x11. RMW means a read (we_o=0) followed by a write (we_o=1) to the same address.
- R3: The write half of an RMW carries the value just read ORed with the mask. The plain writes to 0x24 and 0x11 carry 0x00 and 0x04 whatever the register held before.
- R4: Each checkpoint keeps req_o low for exactly WAIT_CYC cycles after the preceding write is acknowledged, then reads address 0x03. Every other access follows the previous acknowledge with no idle cycle.
- R5: If bit CAL_BIT (default 4) of the status value read at a checkpoint is 0, the sequence stops after that read and reports err_o=1 with err_code_o=2'b01.
- R6: If an access is not acknowledged by the TIMEOUT_CYC-th clock edge with req_o high, the sequence stops. req_o is dropped and the block reports err_o=1 with err_code_o=2'b10.
- R7: After the final write is acknowledged, done_o=1 with err_o=0 and err_code_o=0. done_o and err_o are sticky, and neither state issues a request.
- R8: While req_o is high and unacknowledged, addr_o, we_o and wdata_o stay unchanged.
- R9: The status register at 0x03 is only read, never written.
- R10: Any acknowledge latency up to TIMEOUT_CYC-1 cycles lets the full sequence complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset; the sequence starts when it is released |
| req_o | output | 1 | Access request to the register port |
| we_o | output | 1 | 1 = write, 0 = read |
| addr_o | output | ADDR_W | PHY register offset |
| wdata_o | output | DATA_W | Write data |
| ack_i | input | 1 | Access complete; consumed on a clock edge where req_o is high |
| rdata_i | input | DATA_W | Read data, valid while ack_i is high on a read |
| done_o | output | 1 | Sequence completed (sticky) |
| err_o | output | 1 | Sequence aborted (sticky) |
| err_code_o | output | 2 | 00 none, 01 calibration not done, 10 access timeout |

## Verification
The assertions assume the register port behaves as a well-formed slave. It raises ack_i only while req_o is high, presents rdata_i in the same cycle as the acknowledge, and treats each acknowledged edge as exactly one completed access. The bench models a slave that does this and nothing else. The model answers from a register image after a chosen latency, can be told never to answer a given access, and derives the status flag from one of three calibration behaviours. Latency is swept from zero up to the timeout window itself.

// File: rtl/phy_cal_pkg.sv
package phy_cal_pkg;

  typedef enum logic [1:0] {
    K_WR  = 2'd0,
    K_RMW = 2'd1,
    K_CHK = 2'd2
  } step_kind_e;

  typedef enum logic [2:0] {
    S_START = 3'd0,
    S_DELAY = 3'd1,
    S_READ  = 3'd2,
    S_WRITE = 3'd3,
    S_DONE  = 3'd4,
    S_ERR   = 3'd5
  } seq_state_e;

  localparam int unsigned NUM_STEPS = 16;
  localparam int unsigned STEP_W    = $clog2(NUM_STEPS);

  localparam logic [1:0] ERR_NONE    = 2'd0;
  localparam logic [1:0] ERR_CAL     = 2'd1;
  localparam logic [1:0] ERR_TIMEOUT = 2'd2;

  function automatic step_kind_e step_kind(input logic [STEP_W-1:0] idx);
    case (int'(idx))
      0, 15:   return K_WR;
      3, 5:    return K_CHK;
      default: return K_RMW;
    endcase
  endfunction

endpackage

// File: rtl/phy_cal_steps.sv
module phy_cal_steps
  import phy_cal_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 8
) (
  input  logic [STEP_W-1:0] idx_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] val_o
);

  logic [7:0] a8;
  logic [7:0] v8;

  // val is the OR mask for RMW steps, the literal for plain writes
  always_comb begin
    case (int'(idx_i))
      0:       begin a8 = 8'h24; v8 = 8'h00; end
      1:       begin a8 = 8'h01; v8 = 8'h40; end
      2:       begin a8 = 8'h02; v8 = 8'h02; end
      3:       begin a8 = 8'h03; v8 = 8'h00; end
      4:       begin a8 = 8'h01; v8 = 8'h02; end
      5:       begin a8 = 8'h03; v8 = 8'h00; end
      6:       begin a8 = 8'h06; v8 = 8'h03; end
      7:       begin a8 = 8'h08; v8 = 8'h02; end
      8:       begin a8 = 8'h20; v8 = 8'h01; end
      9:       begin a8 = 8'h07; v8 = 8'hFF; end
      10:      begin a8 = 8'h09; v8 = 8'hFF; end
      11:      begin a8 = 8'h21; v8 = 8'hFF; end
      12:      begin a8 = 8'h22; v8 = 8'h01; end
      13:      begin a8 = 8'h23; v8 = 8'h01; end
      14:      begin a8 = 8'h0F; v8 = 8'h07; end
      default: begin a8 = 8'h11; v8 = 8'h04; end
    endcase
  end

  assign addr_o = ADDR_W'(a8);
  assign val_o  = DATA_W'(v8);

endmodule

// File: rtl/phy_cal_cnt.sv
module phy_cal_cnt #(
  parameter int unsigned LIMIT = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic en_i,
  output logic hit_o
);

  localparam int unsigned CNT_W = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (en_i)  cnt_q <= cnt_q + 1'b1;
  end

  // hit on the LIMIT-th enabled edge since the last clear
  assign hit_o = en_i && (cnt_q == CNT_W'(LIMIT - 1));

endmodule

// File: rtl/phy_cal_ctrl.sv
module phy_cal_ctrl
  import phy_cal_pkg::*;
#(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned CAL_BIT = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DATA_W-1:0] step_val_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  input  logic              dly_hit_i,
  input  logic              to_hit_i,
  output logic [STEP_W-1:0] step_o,
  output logic              req_o,
  output logic              we_o,
  output logic [DATA_W-1:0] wdata_o,
  output logic              dly_en_o,
  output logic              to_en_o,
  output logic              to_clr_o,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);

  seq_state_e        state_q, state_d;
  logic [STEP_W-1:0] step_q, step_d, step_nxt;
  logic [DATA_W-1:0] merged_q, merged_d;
  logic [1:0]        code_q, code_d;
  step_kind_e        cur_kind, nxt_kind;
  logic              last_step, adv;

  assign step_nxt  = step_q + 1'b1;
  assign cur_kind  = step_kind(step_q);
  assign nxt_kind  = step_kind(step_nxt);
  assign last_step = (step_q == STEP_W'(NUM_STEPS - 1));

  function automatic seq_state_e entry_state(input step_kind_e k);
    case (k)
      K_WR:    return S_WRITE;
      K_CHK:   return S_DELAY;
      default: return S_READ;
    endcase
  endfunction

  always_comb begin
    state_d  = state_q;
    step_d   = step_q;
    merged_d = merged_q;
    code_d   = code_q;
    adv      = 1'b0;
    case (state_q)
      S_START: state_d = entry_state(cur_kind);
      S_DELAY: if (dly_hit_i) state_d = S_READ;
      S_READ: begin
        if (ack_i) begin
          if (cur_kind == K_CHK) begin
            if (rdata_i[CAL_BIT]) begin
              adv = 1'b1;
            end else begin
              state_d = S_ERR;
              code_d  = ERR_CAL;
            end
          end else begin
            merged_d = rdata_i | step_val_i;
            state_d  = S_WRITE;
          end
        end else if (to_hit_i) begin
          state_d = S_ERR;
          code_d  = ERR_TIMEOUT;
        end
      end
      S_WRITE: begin
        if (ack_i) begin
          adv = 1'b1;
        end else if (to_hit_i) begin
          state_d = S_ERR;
          code_d  = ERR_TIMEOUT;
        end
      end
      default: ;
    endcase
    if (adv) begin
      if (last_step) begin
        state_d = S_DONE;
      end else begin
        step_d  = step_nxt;
        state_d = entry_state(nxt_kind);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= S_START;
      step_q   <= '0;
      merged_q <= '0;
      code_q   <= ERR_NONE;
    end else begin
      state_q  <= state_d;
      step_q   <= step_d;
      merged_q <= merged_d;
      code_q   <= code_d;
    end
  end

  assign step_o     = step_q;
  assign req_o      = (state_q == S_READ) || (state_q == S_WRITE);
  assign we_o       = (state_q == S_WRITE);
  assign wdata_o    = (cur_kind == K_WR) ? step_val_i : merged_q;
  assign dly_en_o   = (state_q == S_DELAY);
  assign to_en_o    = req_o && !ack_i;
  assign to_clr_o   = !req_o || ack_i;
  assign done_o     = (state_q == S_DONE);
  assign err_o      = (state_q == S_ERR);
  assign err_code_o = code_q;

endmodule

// File: rtl/phy_cal_seq.sv
module phy_cal_seq
  import phy_cal_pkg::*;
#(
  parameter int unsigned WAIT_CYC    = 2500000,
  parameter int unsigned TIMEOUT_CYC = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned CAL_BIT     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  output logic              req_o,
  output logic              we_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] wdata_o,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] rdata_i,
  output logic              done_o,
  output logic              err_o,
  output logic [1:0]        err_code_o
);

  logic [STEP_W-1:0] step;
  logic [DATA_W-1:0] step_val;
  logic              dly_en, dly_hit;
  logic              to_en, to_clr, to_hit;

  phy_cal_steps #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) u_steps (
    .idx_i (step),
    .addr_o(addr_o),
    .val_o (step_val)
  );

  phy_cal_cnt #(
    .LIMIT(WAIT_CYC)
  ) u_dly_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (!dly_en),
    .en_i  (dly_en),
    .hit_o (dly_hit)
  );

  phy_cal_cnt #(
    .LIMIT(TIMEOUT_CYC)
  ) u_to_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (to_clr),
    .en_i  (to_en),
    .hit_o (to_hit)
  );

  phy_cal_ctrl #(
    .DATA_W (DATA_W),
    .CAL_BIT(CAL_BIT)
  ) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_val_i(step_val),
    .ack_i     (ack_i),
    .rdata_i   (rdata_i),
    .dly_hit_i (dly_hit),
    .to_hit_i  (to_hit),
    .step_o    (step),
    .req_o     (req_o),
    .we_o      (we_o),
    .wdata_o   (wdata_o),
    .dly_en_o  (dly_en),
    .to_en_o   (to_en),
    .to_clr_o  (to_clr),
    .done_o    (done_o),
    .err_o     (err_o),
    .err_code_o(err_code_o)
  );

endmodule

// File: rtl/phy_cal_seq_chk.sv
module phy_cal_seq_chk #(
  parameter int unsigned TIMEOUT_CYC = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned DATA_W      = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_o,
  input logic              we_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [DATA_W-1:0] wdata_o,
  input logic              ack_i,
  input logic              done_o,
  input logic              err_o,
  input logic [1:0]        err_code_o
);

  int unsigned pend_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pend_cnt <= 0;
    else if (!req_o || ack_i)  pend_cnt <= 0;
    else                       pend_cnt <= pend_cnt + 1;
  end

  p_reset_quiet_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (!req_o && !done_o && !err_o && err_code_o == 2'd0));

  p_code_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> (err_code_o == 2'd1 || err_code_o == 2'd2));

  p_err_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> (err_o && !req_o && $stable(err_code_o)));

  p_req_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (pend_cnt < TIMEOUT_CYC));

  p_done_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (done_o && !req_o && !err_o && err_code_o == 2'd0));

  p_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=>
      (err_o || (req_o && $stable(addr_o) && $stable(we_o) && $stable(wdata_o))));

  p_no_status_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && we_o) |-> (addr_o != ADDR_W'(3)));

endmodule

bind phy_cal_seq phy_cal_seq_chk #(
  .TIMEOUT_CYC(TIMEOUT_CYC),
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W)
) u_chk (.*);

// File: tb/tb_phy_cal_seq.sv
module tb_phy_cal_seq;

  localparam int unsigned AW    = 6;
  localparam int unsigned DW    = 8;
  localparam int unsigned WAIT  = 8;
  localparam int unsigned TO    = 6;
  localparam int          NSTEP = 16;
  localparam int          NONE  = 999;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req, we, done, err;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          ack_r = 1'b0;
  logic [DW-1:0] rdata_r = '0;
  logic [1:0]    code;

  always #2 clk = ~clk;

  phy_cal_seq #(
    .WAIT_CYC   (WAIT),
    .TIMEOUT_CYC(TO),
    .ADDR_W     (AW),
    .DATA_W     (DW),
    .CAL_BIT    (4)
  ) dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .req_o     (req),
    .we_o      (we),
    .addr_o    (addr),
    .wdata_o   (wdata),
    .ack_i     (ack_r),
    .rdata_i   (rdata_r),
    .done_o    (done),
    .err_o     (err),
    .err_code_o(code)
  );

  int checks = 0;
  int errors = 0;

  logic [7:0] mem[64];
  logic [7:0] exp_mem[64];
  int lat = 0, stall_idx = NONE, cal_mode = 0;
  int rcnt = 0, idle_cnt = 0, hi_cnt = 0, hold_bad = 0;
  logic [AW-1:0] h_addr;
  logic          h_we;
  logic [7:0]    h_wd;

  int         log_n = 0;
  logic       log_we[64];
  logic [7:0] log_addr[64];
  logic [7:0] log_data[64];
  int         log_idle[64];

  int         e_n;
  logic       e_we[64];
  logic [7:0] e_addr[64];
  logic [7:0] e_data[64];

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  // status flag behaviour: 0 always ready, 1 never ready, 2 lost once pad1 bit1 is set
  function automatic logic [7:0] status_of(input logic [7:0] base, input logic [7:0] pad1,
                                           input int mode);
    case (mode)
      0:       return base | 8'h10;
      1:       return base & 8'hEF;
      default: return pad1[1] ? (base & 8'hEF) : (base | 8'h10);
    endcase
  endfunction

  // kind: 0 plain write, 1 read-OR-write, 2 checkpoint
  task automatic tb_step(input int s, output int k, output logic [7:0] a, output logic [7:0] v);
    k = 1; v = 8'h00;
    case (s)
      0:  begin k = 0; a = 8'h24; v = 8'h00; end
      1:  begin a = 8'h01; v = 8'h40; end
      2:  begin a = 8'h02; v = 8'h02; end
      3:  begin k = 2; a = 8'h03; end
      4:  begin a = 8'h01; v = 8'h02; end
      5:  begin k = 2; a = 8'h03; end
      6:  begin a = 8'h06; v = 8'h03; end
      7:  begin a = 8'h08; v = 8'h02; end
      8:  begin a = 8'h20; v = 8'h01; end
      9:  begin a = 8'h07; v = 8'hFF; end
      10: begin a = 8'h09; v = 8'hFF; end
      11: begin a = 8'h21; v = 8'hFF; end
      12: begin a = 8'h22; v = 8'h01; end
      13: begin a = 8'h23; v = 8'h01; end
      14: begin a = 8'h0F; v = 8'h07; end
      default: begin k = 0; a = 8'h11; v = 8'h04; end
    endcase
  endtask

  // register-port slave model
  always @(negedge clk) begin
    if (!rst_n) begin
      ack_r = 1'b0; rcnt = 0; idle_cnt = 0; hi_cnt = 0;
    end else begin
      if (ack_r) begin
        ack_r = 1'b0; rcnt = 0; hi_cnt = 0;
      end
      if (req) begin
        hi_cnt++;
        if (rcnt == 0) begin
          h_addr = addr; h_we = we; h_wd = wdata;
        end else if (addr != h_addr || we != h_we || (we && wdata != h_wd)) begin
          hold_bad++;
        end
        if (rcnt == lat && log_n != stall_idx && log_n < 64) begin
          ack_r = 1'b1;
          if (we) begin
            mem[int'(addr)] = wdata;
            rdata_r = '0;
            log_data[log_n] = wdata;
          end else begin
            rdata_r = (addr == AW'(3)) ? status_of(mem[3], mem[1], cal_mode) : mem[int'(addr)];
            log_data[log_n] = rdata_r;
          end
          log_we[log_n]   = we;
          log_addr[log_n] = 8'(addr);
          log_idle[log_n] = idle_cnt;
          idle_cnt = 0;
          log_n++;
        end else begin
          rcnt++;
        end
      end else if (!done && !err) begin
        idle_cnt++;
      end
    end
  end

  task automatic run(input int l, input int mode, input int stall, input string rq);
    int  cyc, lim, k, n_end, hi_end, n_cmp, exp_idle, exp_code;
    bit  cal_fail;
    logic [7:0] a, v, st, cur;
    lat = l; cal_mode = mode; stall_idx = stall;
    rst_n = 1'b0;
    for (int i = 0; i < 64; i++) begin
      mem[i] = 8'(i * 29 + 7);
    end
    mem[3] = 8'hA5;
    for (int i = 0; i < 64; i++) exp_mem[i] = mem[i];
    log_n = 0; hold_bad = 0;
    repeat (3) @(negedge clk);
    chk(!req && !done && !err && code == 2'd0, "R1", "outputs in reset",
        int'({req, done, err, code}), 0);
    rst_n = 1'b1;
    cyc = 0;
    while (!(done || err) && cyc < 3000) begin
      @(negedge clk);
      cyc++;
    end
    chk(cyc < 3000, "R7", "watchdog: sequence never ended", cyc, 3000);
    hi_end = hi_cnt;
    n_end  = log_n;
    repeat (12) @(negedge clk);
    chk(!req && log_n == n_end, "R7", "requests after end", log_n, n_end);

    // expected access list from the step table
    lim = (l >= int'(TO)) ? 0 : stall;
    e_n = 0; cal_fail = 1'b0;
    for (int s = 0; s < NSTEP && !cal_fail; s++) begin
      tb_step(s, k, a, v);
      if (k == 0) begin
        if (e_n < lim) exp_mem[a] = v;
        e_we[e_n] = 1'b1; e_addr[e_n] = a; e_data[e_n] = v; e_n++;
      end else if (k == 1) begin
        cur = exp_mem[a];
        e_we[e_n] = 1'b0; e_addr[e_n] = a; e_data[e_n] = cur; e_n++;
        if (e_n < lim) exp_mem[a] = cur | v;
        e_we[e_n] = 1'b1; e_addr[e_n] = a; e_data[e_n] = cur | v; e_n++;
      end else begin
        st = status_of(exp_mem[3], exp_mem[1], mode);
        e_we[e_n] = 1'b0; e_addr[e_n] = a; e_data[e_n] = st; e_n++;
        if (!st[4]) cal_fail = 1'b1;
      end
    end
    if (lim < e_n) begin
      e_n = lim;
      exp_code = 2;
    end else begin
      exp_code = cal_fail ? 1 : 0;
    end

    if (exp_code == 0) begin
      chk(done && !err && code == 2'd0, "R7", "done flag", int'({done, err, code}), 4'b1000);
    end else if (exp_code == 1) begin
      chk(err && !done && code == 2'd1, "R5", "calibration error code", int'(code), 1);
    end else begin
      chk(err && !done && code == 2'd2, "R6", "timeout error code", int'(code), 2);
      chk(hi_end == int'(TO), "R6", "cycles req held before abort", hi_end, TO);
    end
    chk(log_n == e_n, rq, "access count", log_n, e_n);
    n_cmp = (log_n < e_n) ? log_n : e_n;
    for (int i = 0; i < n_cmp; i++) begin
      chk(log_we[i] == e_we[i] && log_addr[i] == e_addr[i], "R2", $sformatf("access %0d we/addr", i),
          int'({log_we[i], log_addr[i]}), int'({e_we[i], e_addr[i]}));
      chk(log_data[i] == e_data[i], "R3", $sformatf("access %0d data", i),
          int'(log_data[i]), int'(e_data[i]));
      if (i > 0) begin
        exp_idle = (e_addr[i] == 8'h03 && !e_we[i]) ? int'(WAIT) : 0;
        chk(log_idle[i] == exp_idle, "R4", $sformatf("idle before access %0d", i),
            log_idle[i], exp_idle);
      end
    end
    for (int i = 0; i < 64; i++) begin
      chk(mem[i] == exp_mem[i], (i == 3) ? "R9" : "R3", $sformatf("register 0x%02h", i),
          int'(mem[i]), int'(exp_mem[i]));
    end
    chk(hold_bad == 0, "R8", "request changed before ack", hold_bad, 0);
  endtask

  initial begin
    // R10 latency sweep; latency TO must time out (R6)
    for (int l = 0; l <= int'(TO); l++) begin
      run(l, 0, NONE, (l < int'(TO)) ? "R10" : "R6");
    end
    run(1, 1, NONE, "R5");   // first checkpoint fails
    run(2, 2, NONE, "R5");   // second checkpoint fails
    run(2, 0, 5,    "R6");   // stall mid-sequence
    run(0, 0, 27,   "R6");   // stall on the final write
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R7 global watchdog expired: actual 190000 expected 0");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule